// File: doc/BRIEF.md
# Serial Channel Termination Configuration Latch

This block holds the termination setting of a bank of discrete input channels and an enable for built-in test. Software writes the setting through a four-wire serial port. The port has a serial clock, an active-low select, a register-select line and serial data in and out. While register-select is low, every rising serial clock edge pushes one bit into a nine-bit shift register. The rising edge of the select then copies that register into a holding latch, and the channel outputs are decoded from the latch. The old shift contents leave on the serial output while new bits arrive. A write therefore also reads back the present setting, and devices can be chained one after another.

Each channel gets a pull-up enable, a pull-down enable and a test stimulus. After reset every channel is high impedance, and it stays that way until the first write that completes. A timed hold-off window after reset rejects writes. A low-supply flag that stays asserted for a set time clears the whole block and restarts the hold-off window. The serial pins are resynchronised into the system clock domain, so every serial edge is acted on a few system clocks after it arrives.

Top module: `chan_cfg_latch`

## Requirements
- R1: On each rising serial clock edge with select low and register-select low, the serial data bit enters bit 1 (index 0), every bit moves one place toward bit 9 (index 8), and `sdo` then presents bit 9. Words are therefore sent with bit 9 first.
- R2: `sdo_oe` is 1 only while select is low and register-select is low, and 0 otherwise.
- R3: The latch takes the shift register contents only on a rising edge of select with register-select low. Until that edge the channel outputs keep the previous setting.
- R4: With the latch loaded and bit 9 = 0, channel n has `pull_up_en[n]`=1 when bit n+1 is 1, and `pull_dn_en[n]`=1 when that bit is 0. Both are never on together, and `test_stim` is 0.
- R5: With the latch loaded and bit 9 = 1, `test_mode` is 1, all pull enables are 0, and `test_stim[n]` equals latch bit n+1.
- R6: After reset the shift register and the latch are zero, and all outputs are 0 until the first accepted write. Latching an all-zero word is accepted and turns every pull-down on.
- R7: A select rising edge less than HOLD_NS after reset release, or after the end of a supply clear, leaves the latch and the outputs unchanged. Shifting still takes place during the window.
- R8: `supply_low` held for SAG_NS of consecutive clock time clears the shift register and the latch, and returns all channels to high impedance. A shorter pulse has no effect.
- R9: In an 18-clock transfer, `sdo` first gives the previous nine-bit contents (bit 9 first) and then the first nine bits sent. The latch ends up with the last nine bits.
- R10: Serial clock edges with select high, or with register-select high, leave the shift register unchanged. A select rising edge with register-select high does not load the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock |
| cs_n | input | 1 | Active-low serial select |
| sel_data | input | 1 | Register select: 1 = data register (not this block), 0 = configuration |
| sdi | input | 1 | Serial data in |
| supply_low | input | 1 | Low-supply flag from an external monitor |
| sdo | output | 1 | Serial data out (bit 9 of the shift register) |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| pull_up_en | output | CH | Per-channel pull-up enable |
| pull_dn_en | output | CH | Per-channel pull-down enable |
| test_stim | output | CH | Per-channel test stimulus |
| test_mode | output | 1 | Built-in test active |

## Verification
The bench builds the block with CLK_KHZ=1000, HOLD_NS=200000 and SAG_NS=9000. These values give a hold-off of 200 clock ticks and a supply-sag threshold of 9 ticks. With these settings, a complete nine-bit write fits inside the hold-off window, so the bench can show a write being rejected and then accepted later. A 5-tick supply pulse and a 20-tick supply pulse fall on either side of the sag threshold. With CH left at 8, the 18-clock chained transfer and the test-mode mapping run at full width.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [1:0] {
    TERM_HIZ = 2'd0,
    TERM_PDN = 2'd1,
    TERM_PUP = 2'd2,
    TERM_BIT = 2'd3
  } term_e;

  // Converts a duration in ns to clock ticks, with a floor of one tick.
  function automatic int ticks_of(input longint khz, input longint ns);
    longint t;
    t = (khz * ns) / 64'd1000000;
    if (t < 1) return 1;
    return int'(t);
  endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] pipe_d [STAGES];

  always_comb begin
    pipe_d[0] = d;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= pipe_d[i];
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/cfgl_guard.sv
module cfgl_guard #(
  parameter int HOLD_TICKS = 200,
  parameter int SAG_TICKS  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_s,
  output logic wr_ok,
  output logic sag_clr
);

  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int SW = $clog2(SAG_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_TICKS);
  localparam logic [SW-1:0] SAG_TOP   = SW'(SAG_TICKS);

  logic [HW-1:0] hold_q, hold_d;
  logic [SW-1:0] sag_q, sag_d;

  assign sag_clr = (sag_q == SAG_TOP);
  assign wr_ok   = (hold_q == '0);

  always_comb begin
    if (!low_s)              sag_d = '0;
    else if (sag_q == SAG_TOP) sag_d = sag_q;
    else                     sag_d = sag_q + 1'b1;
  end

  always_comb begin
    if (sag_clr)             hold_d = HOLD_LOAD;
    else if (hold_q != '0)   hold_d = hold_q - 1'b1;
    else                     hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= HOLD_LOAD;
      sag_q  <= '0;
    end else begin
      hold_q <= hold_d;
      sag_q  <= sag_d;
    end
  end

  // R7
  hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sag_clr |=> !wr_ok);

  // R8
  sag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sag_clr) |-> $past(low_s));

endmodule

// File: rtl/cfgl_shreg.sv
module cfgl_shreg #(
  parameter int CH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_ok,
  input  logic        sclk_s,
  input  logic        cs_n_s,
  input  logic        sel_s,
  input  logic        sdi_s,
  output logic        sdo,
  output logic        sdo_oe,
  output logic [CH:0] lat_q,
  output logic        cfgd_q
);

  localparam int NB = CH + 1;

  logic          sclk_d, csn_d;
  logic [NB-1:0] sr_q, sr_d;
  logic [NB-1:0] lat_d;
  logic          cfgd_d;
  logic          sclk_rise, cs_rise, shift_en, load_en;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_d;
    cs_rise   = cs_n_s & ~csn_d;
    shift_en  = sclk_rise & ~cs_n_s & ~sel_s;
    load_en   = cs_rise & ~sel_s & wr_ok;
  end

  always_comb begin
    sr_d   = sr_q;
    lat_d  = lat_q;
    cfgd_d = cfgd_q;
    if (clr) begin
      sr_d   = '0;
      lat_d  = '0;
      cfgd_d = 1'b0;
    end else begin
      if (shift_en) sr_d = {sr_q[NB-2:0], sdi_s};
      if (load_en) begin
        lat_d  = sr_q;
        cfgd_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
      sr_q   <= '0;
      lat_q  <= '0;
      cfgd_q <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= cs_n_s;
      sr_q   <= sr_d;
      lat_q  <= lat_d;
      cfgd_q <= cfgd_d;
    end
  end

  assign sdo    = sr_q[NB-1];
  assign sdo_oe = ~cs_n_s & ~sel_s;

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (sr_q[0] == $past(sdi_s)));

  // R1
  shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (sdo == $past(sr_q[NB-2])));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(sr_q));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !clr) |=> ($stable(lat_q) && $stable(cfgd_q)));

  // R7
  holdoff_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !sel_s && !wr_ok && !clr) |=> ($stable(lat_q) && $stable(cfgd_q)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lat_q == '0 && !cfgd_q && sr_q == '0));

endmodule

// File: rtl/cfgl_term.sv
module cfgl_term
  import cfgl_pkg::*;
#(
  parameter int CH = 8
) (
  input  logic [CH:0]   lat_q,
  input  logic          cfgd_q,
  output logic [CH-1:0] pull_up_en,
  output logic [CH-1:0] pull_dn_en,
  output logic [CH-1:0] test_stim,
  output logic          test_mode
);

  assign test_mode = cfgd_q & lat_q[CH];

  for (genvar n = 0; n < CH; n++) begin : g_chan
    term_e mode;
    always_comb begin
      if (!cfgd_q)        mode = TERM_HIZ;
      else if (lat_q[CH]) mode = TERM_BIT;
      else if (lat_q[n])  mode = TERM_PUP;
      else                mode = TERM_PDN;
      pull_up_en[n] = (mode == TERM_PUP);
      pull_dn_en[n] = (mode == TERM_PDN);
      test_stim[n]  = (mode == TERM_BIT) & lat_q[n];
    end
  end

endmodule

// File: rtl/chan_cfg_latch.sv
module chan_cfg_latch #(
  parameter int CH          = 8,
  parameter int CLK_KHZ     = 100_000,
  parameter int HOLD_NS     = 200_000,
  parameter int SAG_NS      = 9_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sel_data,
  input  logic          sdi,
  input  logic          supply_low,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [CH-1:0] pull_up_en,
  output logic [CH-1:0] pull_dn_en,
  output logic [CH-1:0] test_stim,
  output logic          test_mode
);

  localparam int HOLD_TICKS = cfgl_pkg::ticks_of(CLK_KHZ, HOLD_NS);
  localparam int SAG_TICKS  = cfgl_pkg::ticks_of(CLK_KHZ, SAG_NS);
  localparam int NIN        = 5;
  localparam logic [NIN-1:0] IN_RST = 5'b00110;

  logic [1:0]     rst_pipe;
  logic           rst_int_n;
  logic [NIN-1:0] pins_s;
  logic           sclk_s, cs_n_s, sel_s, sdi_s, low_s;
  logic           wr_ok, sag_clr;
  logic [CH:0]    lat_q;
  logic           cfgd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  cfgl_sync #(
    .W       (NIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IN_RST)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({supply_low, sdi, sel_data, cs_n, sclk}),
    .q     (pins_s)
  );

  assign {low_s, sdi_s, sel_s, cs_n_s, sclk_s} = pins_s;

  cfgl_guard #(
    .HOLD_TICKS (HOLD_TICKS),
    .SAG_TICKS  (SAG_TICKS)
  ) i_guard (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .low_s   (low_s),
    .wr_ok   (wr_ok),
    .sag_clr (sag_clr)
  );

  cfgl_shreg #(
    .CH (CH)
  ) i_shreg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (sag_clr),
    .wr_ok  (wr_ok),
    .sclk_s (sclk_s),
    .cs_n_s (cs_n_s),
    .sel_s  (sel_s),
    .sdi_s  (sdi_s),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .lat_q  (lat_q),
    .cfgd_q (cfgd_q)
  );

  cfgl_term #(
    .CH (CH)
  ) i_term (
    .lat_q      (lat_q),
    .cfgd_q     (cfgd_q),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .test_stim  (test_stim),
    .test_mode  (test_mode)
  );

  // R4
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pull_up_en & pull_dn_en) == '0);

  // R5
  bit_nopull_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    test_mode |-> (pull_up_en == '0 && pull_dn_en == '0));

  // R6
  unconfigured_hiz_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfgd_q |-> (pull_up_en == '0 && pull_dn_en == '0 && test_stim == '0 && !test_mode));

endmodule

// File: tb/test_chan_cfg_latch.sv
`timescale 1ns/1ps
module test_chan_cfg_latch;

  localparam int CH   = 8;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sel_data = 1'b1, sdi = 1'b0, supply_low = 1'b0;
  logic sdo, sdo_oe, test_mode;
  logic [CH-1:0] pull_up_en, pull_dn_en, test_stim;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  chan_cfg_latch #(
    .CH          (CH),
    .CLK_KHZ     (1000),
    .HOLD_NS     (200_000),
    .SAG_NS      (9_000),
    .SYNC_STAGES (2)
  ) i_chan_cfg_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .sel_data   (sel_data),
    .sdi        (sdi),
    .supply_low (supply_low),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .test_stim  (test_stim),
    .test_mode  (test_mode)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] expect_out(input logic [8:0] w, input bit cfgd);
    if (!cfgd)    return '0;
    if (w[8])     return {1'b1, w[7:0], 8'h00, 8'h00};
    return {1'b0, 8'h00, w[7:0], ~w[7:0]};
  endfunction

  task automatic check_out(input string req, input logic [8:0] w, input bit cfgd);
    check(req, {7'd0, test_mode, test_stim, pull_up_en, pull_dn_en}, {7'd0, expect_out(w, cfgd)});
  endtask

  // Shifts n bits (MSB of the n-bit field first) and captures sdo before each edge.
  task automatic spi_shift(input int n, input logic [17:0] din, output logic [17:0] dout);
    dout = '0;
    sel_data = 1'b0;
    cs_n = 1'b0;
    wclk(HALF);
    check("R2 oe with select low", {31'd0, sdo_oe}, 32'd1);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = din[i];
      wclk(HALF);
      dout[i] = sdo;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_end();
    wclk(HALF);
    cs_n = 1'b1;
    wclk(HALF);
    sel_data = 1'b1;
    wclk(HALF);
  endtask

  task automatic write9(input logic [8:0] w, output logic [8:0] prev);
    logic [17:0] o;
    spi_shift(9, {9'd0, w}, o);
    spi_end();
    prev = o[8:0];
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wclk(4);
    check_out("R6 outputs after reset", 9'h000, 1'b0);
    check("R2 oe idle", {31'd0, sdo_oe}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_holdoff();
    logic [8:0] p;
    write9(9'h0A5, p);
    check("R6 shift register zero after reset", {23'd0, p}, 32'h000);
    check_out("R7 write inside hold-off ignored", 9'h000, 1'b0);
    wclk(150);
  endtask

  task automatic t_first_write();
    logic [17:0] o;
    spi_shift(9, 18'h0005A, o);
    check("R7 shifting continued in hold-off", {14'd0, o}, 32'h0A5);
    check_out("R3 no change before select rise", 9'h000, 1'b0);
    spi_end();
    check_out("R4 first write decoded", 9'h05A, 1'b1);
  endtask

  task automatic t_update();
    logic [17:0] o;
    spi_shift(9, 18'h000C3, o);
    check_out("R3 previous setting kept", 9'h05A, 1'b1);
    check("R1 readback of present word", {14'd0, o}, 32'h05A);
    spi_end();
    check_out("R4 second write decoded", 9'h0C3, 1'b1);
  endtask

  task automatic t_test_mode();
    logic [8:0] p;
    write9(9'h13C, p);
    check("R1 readback before test write", {23'd0, p}, 32'h0C3);
    check_out("R5 test mode stimulus", 9'h13C, 1'b1);
  endtask

  task automatic t_ignore();
    logic [8:0] p;
    sel_data = 1'b1;
    cs_n = 1'b0;
    sdi = 1'b1;
    wclk(HALF);
    check("R2 oe with data register selected", {31'd0, sdo_oe}, 32'd0);
    for (int i = 0; i < 9; i++) begin
      sclk = 1'b1; wclk(HALF);
      sclk = 1'b0; wclk(HALF);
    end
    cs_n = 1'b1;
    wclk(HALF);
    check_out("R10 select rise with data register selected", 9'h13C, 1'b1);
    sel_data = 1'b0;
    for (int i = 0; i < 9; i++) begin
      sclk = 1'b1; wclk(HALF);
      sclk = 1'b0; wclk(HALF);
    end
    sel_data = 1'b1;
    wclk(HALF);
    write9(9'h0FF, p);
    check("R10 shift register untouched", {23'd0, p}, 32'h13C);
    check_out("R4 all pull-ups", 9'h0FF, 1'b1);
  endtask

  task automatic t_chain();
    logic [17:0] o;
    spi_shift(18, {9'h155, 9'h0AA}, o);
    spi_end();
    check("R9 first nine out are previous word", {23'd0, o[17:9]}, 32'h0FF);
    check("R9 next nine out are first word sent", {23'd0, o[8:0]}, 32'h155);
    check_out("R9 latch holds last nine", 9'h0AA, 1'b1);
  endtask

  task automatic t_sag();
    logic [8:0] p;
    supply_low = 1'b1;
    wclk(5);
    supply_low = 1'b0;
    wclk(20);
    check_out("R8 short low pulse ignored", 9'h0AA, 1'b1);
    supply_low = 1'b1;
    wclk(20);
    check_out("R8 sustained low clears", 9'h000, 1'b0);
    supply_low = 1'b0;
    wclk(5);
    check_out("R8 still cleared after release", 9'h000, 1'b0);
    write9(9'h00F, p);
    check("R8 shift register cleared", {23'd0, p}, 32'h000);
    check_out("R7 write after clear ignored", 9'h000, 1'b0);
    wclk(150);
    write9(9'h0F0, p);
    check("R7 ignored word still shifted", {23'd0, p}, 32'h00F);
    check_out("R4 write after window accepted", 9'h0F0, 1'b1);
  endtask

  task automatic t_zero_write();
    logic [8:0] p;
    write9(9'h000, p);
    check_out("R6 all-zero write enables pull-downs", 9'h000, 1'b1);
  endtask

  initial begin
    t_reset();
    t_holdoff();
    t_first_write();
    t_update();
    t_test_mode();
    t_ignore();
    t_chain();
    t_sag();
    t_zero_write();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule